// File: doc/BRIEF.md
# Lane De-Interleaver With Deskew

This block sits on the receive side of a link that carries several byte lanes interleaved onto one fast byte stream. It counts the valid bytes of that stream into N slots in turn, where N is 2, 3 or 4. It then works out which slot carries which lane and gives each lane its own byte output.

Each lane sends a marker byte once per frame of `FRAME` lane bytes. The upper six bits of the marker are programmable. The lower two bits carry the number of the lane that sent it. From the round in which each slot's marker arrives, the block measures the relative skew of the lanes. It then delays each slot through a short tap line, so that every lane's marker lines up with the marker of the lane that arrives last. After this, bytes that were launched together on different lanes leave the block in the same output beat. Marker bytes are dropped from the output.

A pass-through setting forwards the stream unchanged on lane 0, and no alignment takes place in that setting.

Top module: `lane_deskew_demux`

## Requirements
- R1: `ratio` selects the mode: 0 is pass-through, and 1, 2, 3 give N = 2, 3, 4 lanes. Successive valid input bytes fill slots 0 to N-1 in turn. One slot cycle is called a round.
- R2: A byte is a marker when its bits [7:2] equal `mark_char[7:2]`. Its bits [1:0] give the lane number. Lane L's data appears on `lane_byte[8L+7:8L]`, whichever slot carried it.
- R3: Relative lane skew of up to `SKEW` (4) rounds is removed. In every output beat, all lanes carry bytes that were launched in the same lane round.
- R4: `aligned` rises only after two consecutive marker windows have shown the same per-slot offsets, lane rotation and reference slot. It is therefore still low after round `FRAME` when the stream starts at round 0.
- R5: A relative skew of `SKEW`+1 rounds or more never asserts `aligned`.
- R6: While aligned, four consecutive expected marker positions in the reference slot that hold no correct marker drop `aligned`, set `lost` and restart the search. `lost` clears when alignment is regained. `aligned` and `lost` are never high together.
- R7: Marker rounds produce no output beat. The beats that remain carry every data round in order, with none dropped.
- R8: `lane_vld` stays low until `aligned` has been high. Whenever any lane is valid, lanes 0 to N-1 are all valid and the lanes from N upward are low.
- R9: In pass-through mode, lane 0 repeats `in_byte` and `in_vld` one cycle later. Markers are not removed, `aligned` stays low and lanes 1 to 3 are never valid.
- R10: Reset clears `lane_byte`, `lane_vld`, `aligned` and `lost`.
- R11: Cycles with `in_vld` low advance neither the slot count nor the frame timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_byte | input | 8 | Interleaved high-rate byte |
| in_vld | input | 1 | `in_byte` holds a byte this cycle |
| ratio | input | 2 | Mode select: 0 pass-through, 1/2/3 for 2/3/4 lanes |
| mark_char | input | 8 | Marker pattern; bits [7:2] are compared |
| lane_byte | output | 32 | Deskewed lane bytes, lane L in bits [8L+7:8L] |
| lane_vld | output | 4 | Per-lane byte valid |
| aligned | output | 1 | Lane order and skew are locked |
| lost | output | 1 | Lock was lost and has not yet been regained |

## Verification
The embedded properties check on every cycle the rules that hold regardless of the data. Lanes become valid only together and only after lock. The slot count stays below N. `lost` rises only out of lock and never together with `aligned`. Pass-through never locks. Whether the recovered lane order is right for every rotation, whether the skew is removed for each skew pattern, and whether the data rounds run on without gaps once markers are dropped can only be shown by the bench's sweeps. The same holds for the timing of lock, of loss after four missed markers, and of relock.

// File: rtl/lane_deskew_demux.sv
module lane_deskew_demux #(
  parameter int FRAME = 16,
  parameter int SKEW  = 4
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  in_byte,
  input  logic        in_vld,
  input  logic [1:0]  ratio,
  input  logic [7:0]  mark_char,
  output logic [31:0] lane_byte,
  output logic [3:0]  lane_vld,
  output logic        aligned,
  output logic        lost
);
  localparam int LANES = 4;
  localparam int OW = $clog2(SKEW + 1);
  localparam int FW = $clog2(FRAME);
  localparam int MISS_LIMIT = 4;
  localparam logic [FW-1:0] FR_AFTER_LOCK = FW'((SKEW + 1) % FRAME);

  logic [2:0] nl, rsum, esum;
  logic [3:0] mask;
  logic [1:0] slot, mid, mrot, exp_id;
  logic       last, hit, id_ok, srch, rd;

  assign nl    = {1'b0, ratio} + 3'd1;
  assign mask  = {ratio == 2'd3, ratio >= 2'd2, ratio >= 2'd1, 1'b1};
  assign last  = ({1'b0, slot} == nl - 3'd1);
  assign hit   = in_vld && (in_byte[7:2] == mark_char[7:2]);
  assign mid   = in_byte[1:0];
  assign id_ok = {1'b0, mid} < nl;
  assign rsum  = {1'b0, mid} + nl - {1'b0, slot};
  assign mrot  = (rsum >= nl) ? 2'(rsum - nl) : rsum[1:0];
  assign srch  = (ratio != 2'd0) && !aligned;

  logic          win, wbad, cand, opening, closing, good, same, bad_n;
  logic [OW-1:0] wcnt, mx;
  logic [3:0]    seen, seen_n;
  logic [1:0]    wrot, wref, crot, cref, arot, aref, rot_n, ref_n;
  logic [OW-1:0] off [LANES];
  logic [OW-1:0] off_n [LANES];
  logic [OW-1:0] coff [LANES];
  logic [OW-1:0] dly [LANES];
  logic [OW-1:0] dly_n [LANES];
  logic [FW-1:0] fr;
  logic [2:0]    miss;

  always_comb begin
    seen_n = seen; bad_n = wbad; rot_n = wrot; ref_n = wref; opening = 1'b0;
    for (int j = 0; j < LANES; j++) off_n[j] = off[j];
    if (srch && hit) begin
      if (!win) begin
        opening = 1'b1; seen_n = 4'b0001 << slot; bad_n = !id_ok;
        rot_n = mrot; ref_n = slot; off_n[slot] = '0;
      end else begin
        if (seen[slot] || !id_ok || mrot != wrot) bad_n = 1'b1;
        seen_n[slot] = 1'b1; off_n[slot] = wcnt;
      end
    end
  end

  assign closing = srch && win && in_vld && last && (wcnt == OW'(SKEW));
  assign good    = !bad_n && ((seen_n & mask) == mask);

  always_comb begin
    mx = '0;
    same = cand && (crot == rot_n) && (cref == ref_n);
    for (int j = 0; j < LANES; j++)
      if (3'(j) < nl) begin
        if (off_n[j] > mx) mx = off_n[j];
        if (coff[j] != off_n[j]) same = 1'b0;
      end
    for (int j = 0; j < LANES; j++)
      dly_n[j] = (3'(j) < nl) ? mx - off_n[j] : '0;
  end

  assign esum   = {1'b0, aref} + {1'b0, arot};
  assign exp_id = (esum >= nl) ? 2'(esum - nl) : esum[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0; rd <= 1'b0; win <= 1'b0; wbad <= 1'b0; wcnt <= '0; seen <= '0;
      wrot <= '0; wref <= '0; cand <= 1'b0; crot <= '0; cref <= '0;
      aligned <= 1'b0; lost <= 1'b0; arot <= '0; aref <= '0; fr <= '0; miss <= '0;
      for (int j = 0; j < LANES; j++) begin
        off[j] <= '0; coff[j] <= '0; dly[j] <= '0;
      end
    end else begin
      rd <= in_vld && last;
      if (in_vld) slot <= last ? 2'd0 : slot + 2'd1;
      if (srch && in_vld) begin
        seen <= seen_n; wbad <= bad_n; wrot <= rot_n; wref <= ref_n;
        for (int j = 0; j < LANES; j++) off[j] <= off_n[j];
        if (opening) begin
          win <= 1'b1;
          wcnt <= last ? OW'(1) : '0;
        end else if (win && last) begin
          if (closing) begin
            win <= 1'b0;
            if (good && same) begin
              aligned <= 1'b1; lost <= 1'b0; arot <= rot_n; aref <= ref_n;
              fr <= FR_AFTER_LOCK; miss <= '0; cand <= 1'b0;
              for (int j = 0; j < LANES; j++) dly[j] <= dly_n[j];
            end else if (good) begin
              cand <= 1'b1; crot <= rot_n; cref <= ref_n;
              for (int j = 0; j < LANES; j++) coff[j] <= off_n[j];
            end else begin
              cand <= 1'b0;
            end
          end else begin
            wcnt <= wcnt + OW'(1);
          end
        end
      end
      if (aligned && in_vld) begin
        if (last) fr <= (fr == FW'(FRAME - 1)) ? '0 : fr + FW'(1);
        if (slot == aref && fr == '0) begin
          if (hit && mid == exp_id) miss <= '0;
          else if (miss == 3'(MISS_LIMIT - 1)) begin
            aligned <= 1'b0; lost <= 1'b1; miss <= '0;
          end else miss <= miss + 3'd1;
        end
      end
    end
  end

  logic [7:0] sh [LANES][SKEW+1];
  always_ff @(posedge clk) begin
    for (int j = 0; j < LANES; j++)
      if (in_vld && slot == 2'(j)) begin
        sh[j][0] <= in_byte;
        for (int k = 1; k <= SKEW; k++) sh[j][k] <= sh[j][k-1];
      end
  end

  logic [2:0] tsum [LANES];
  logic [1:0] src [LANES];
  logic [7:0] dl [LANES];
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      tsum[l] = 3'(l) + nl - {1'b0, arot};
      src[l]  = (tsum[l] >= nl) ? 2'(tsum[l] - nl) : tsum[l][1:0];
      dl[l]   = sh[src[l]][dly[src[l]]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_byte <= '0; lane_vld <= '0;
    end else if (ratio == 2'd0) begin
      lane_byte <= {24'd0, in_byte};
      lane_vld  <= {3'b000, in_vld};
    end else begin
      for (int l = 0; l < LANES; l++) begin
        lane_byte[8*l +: 8] <= mask[l] ? dl[l] : 8'd0;
        lane_vld[l] <= rd && aligned && mask[l] && (dl[l][7:2] != mark_char[7:2]);
      end
    end
  end

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, slot} < nl); // R1
  AST_VALID_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio != 2'd0 && lane_vld != 4'd0) |-> $past(aligned)); // R8
  AST_LANES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio != 2'd0 && lane_vld != 4'd0) |-> lane_vld == mask); // R8
  AST_LOCK_LOSS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(aligned && lost)); // R6
  AST_LOSS_FROM_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost) |-> $past(aligned)); // R6
  AST_PASSTHRU_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio == 2'd0) |-> !aligned); // R9
endmodule

// File: tb/lane_deskew_demux_bench.sv
module lane_deskew_demux_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME = 16;
  localparam int NEVER = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  in_byte = 8'd0;
  logic        in_vld = 1'b0;
  logic [1:0]  ratio = 2'd1;
  logic [7:0]  mark_char = 8'hBC;
  logic [31:0] lane_byte;
  logic [3:0]  lane_vld;
  logic        aligned, lost;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_deskew_demux #(.FRAME(FRAME), .SKEW(4)) u_lane_deskew_demux (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_vld(in_vld),
    .ratio(ratio), .mark_char(mark_char), .lane_byte(lane_byte),
    .lane_vld(lane_vld), .aligned(aligned), .lost(lost));

  int checks = 0, fails = 0, bcount = 0;
  int skew [4];
  bit mon_on = 1'b0, have_prev, ever_al;
  int nl_b = 2, vrounds, err_mask, err_id, err_sk, err_ct, err_early;
  logic [4:0] prev, uu, ex;
  logic [7:0] d;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (mon_on && rst_n) begin
      if (lane_vld != 4'd0) begin
        vrounds++;
        if (!ever_al) err_early++;
        if (lane_vld != 4'((1 << nl_b) - 1)) err_mask++;
        uu = lane_byte[4:0];
        for (int l = 0; l < nl_b; l++) begin
          d = lane_byte[l*8 +: 8];
          if (d[7] || d[6:5] != 2'(l)) err_id++;
          if (d[4:0] != uu) err_sk++;
        end
        if (have_prev) begin
          ex = prev + 5'd1;
          if (ex[3:0] == 4'd0) ex = ex + 5'd1;
          if (uu != ex) err_ct++;
        end
        prev = uu; have_prev = 1'b1;
      end
      if (aligned) ever_al = 1'b1;
    end
  end

  task automatic send(input logic [7:0] b, input logic v);
    @(negedge clk);
    in_byte = b; in_vld = v;
  endtask

  task automatic reset_dut(input int mode);
    @(negedge clk);
    rst_n = 1'b0; in_vld = 1'b0; ratio = 2'(mode);
    nl_b = mode + 1; vrounds = 0; err_mask = 0; err_id = 0; err_sk = 0;
    err_ct = 0; err_early = 0; have_prev = 1'b0; ever_al = 1'b0; bcount = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Lane l launches round u = t - skew[l] + 64; marker where u mod FRAME == 0.
  task automatic stream(input int n, input int rot, input int t0, input int t1,
                        input int stop_lo, input int stop_hi);
    for (int t = t0; t < t1; t++)
      for (int c = 0; c < n; c++) begin
        int lane, u;
        logic [7:0] b;
        lane = (c + rot) % n;
        u = t - skew[lane] + 64;
        if (u % FRAME == 0 && !(t >= stop_lo && t < stop_hi))
          b = {mark_char[7:2], 2'(lane)};
        else
          b = {1'b0, 2'(lane), 5'(u)};
        send(b, 1'b1);
        bcount++;
        if (bcount % 7 == 0) send(8'd0, 1'b0); // R11 idle gap
      end
    send(8'd0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    reset_dut(1);
    #1;
    chk(lane_vld == 4'd0 && lane_byte == 32'd0, "R10 outputs after reset", int'(lane_vld), 0);
    chk(!aligned && !lost, "R10 flags after reset", int'({aligned, lost}), 0);

    for (int n = 2; n <= 4; n++)
      for (int rot = 0; rot < n; rot++)
        for (int p = 0; p < 4; p++) begin
          for (int l = 0; l < 4; l++)
            case (p)
              0: skew[l] = 0;
              1: skew[l] = l;
              2: skew[l] = (l == n - 1) ? 4 : 0;
              default: skew[l] = (3 * l + 4) % 5;
            endcase
          reset_dut(n - 1);
          mon_on = 1'b1;
          stream(n, rot, 0, FRAME + 1, NEVER, NEVER);
          repeat (3) @(negedge clk);
          chk(!aligned, "R4 no lock after one frame", int'(aligned), 0);
          stream(n, rot, FRAME + 1, 6 * FRAME, NEVER, NEVER);
          repeat (4) @(negedge clk);
          chk(aligned && !lost, "R1 lock reached", int'({aligned, lost}), 2);
          chk(err_id == 0, "R2 lane order", err_id, 0);
          chk(err_sk == 0, "R3 lanes deskewed", err_sk, 0);
          chk(err_ct == 0, "R7 R11 data rounds continuous", err_ct, 0);
          chk(err_mask == 0 && err_early == 0, "R8 valid only together after lock",
              err_mask + err_early, 0);
          chk(vrounds >= 40, "R1 output beats produced", vrounds, 40);
          mon_on = 1'b0;
        end

    for (int n = 2; n <= 4; n++) begin
      for (int l = 0; l < 4; l++) skew[l] = (l == 0) ? 0 : (l == n - 1) ? 5 : 2;
      reset_dut(n - 1);
      mon_on = 1'b1;
      stream(n, 1 % n, 0, 8 * FRAME, NEVER, NEVER);
      repeat (4) @(negedge clk);
      chk(!ever_al && vrounds == 0, "R5 skew of five never locks", int'(ever_al), 0);
      mon_on = 1'b0;
    end

    skew[0] = 1; skew[1] = 3; skew[2] = 0; skew[3] = 2;
    reset_dut(3);
    stream(4, 1, 0, 96, NEVER, NEVER);
    repeat (4) @(negedge clk);
    chk(aligned, "R6 locked before marker loss", int'(aligned), 1);
    stream(4, 1, 96, 143, 96, NEVER);
    repeat (4) @(negedge clk);
    chk(aligned && !lost, "R6 three misses keep lock", int'({aligned, lost}), 2);
    stream(4, 1, 143, 161, 96, NEVER);
    repeat (4) @(negedge clk);
    chk(!aligned && lost, "R6 fourth miss drops lock", int'({aligned, lost}), 1);
    stream(4, 1, 161, 240, 96, 161);
    repeat (4) @(negedge clk);
    chk(aligned && !lost, "R6 relock clears lost", int'({aligned, lost}), 2);

    reset_dut(0);
    for (int i = 0; i < 10; i++) begin
      logic [7:0] b;
      logic v;
      b = (i == 3) ? 8'hBD : 8'(i * 37 + 5);
      v = (i != 6);
      send(b, v);
      @(posedge clk); #2;
      chk(lane_byte == {24'd0, b}, "R9 pass-through byte", int'(lane_byte), int'(b));
      chk(lane_vld == {3'b000, v} && !aligned, "R9 pass-through valid",
          int'({aligned, lane_vld}), int'(v));
    end
    send(8'd0, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule